// File: doc/BRIEF.md
# Vector Register Issue Interlock with Chaining

This block is the issue interlock of a vector processor that has eight vector registers, eight scalar registers and eight address registers. Every clock it looks at the decoded instruction waiting for issue and decides whether it may go. The instruction arrives as register designators, a functional unit number and two flags for vector memory operations. The functional units report back with first-element and last-element strobes. Scalar and address results report back with write strobes.

Each vector register is idle, reserved or chained. Issuing an instruction that writes a vector register reserves that register. The register becomes chained in the clock when its producer delivers the first element. That clock is the chain slot. A waiting instruction that reads the register may issue exactly in that slot. Its operand is then forwarded from the producing unit, and the bus reports which unit that is. After the slot, a reader must wait until the whole vector has been written.

Vector memory is a pseudo unit. It is the only unit whose first element is timed inside the block: seven clocks after issue. It runs one operation at a time. A vector store never chains. The datapaths and the units themselves are outside this block.

The waiting instruction is a valid/ready stream. `iss_ready` depends only on the instruction fields and the current interlock state, never on `iss_valid`. The instruction issues in any clock where both are high. While `iss_valid` is high and `iss_ready` is low, the source must keep every instruction field stable. There is no buffering inside the block.

Top module: `vchain_issue_ctl`

## Requirements
- R1: After reset every vector register reads idle on `vreg_state`, where two bits per register are used: 0 idle, 1 reserved, 2 chained, and register n sits in bits [2n+1:2n]. No scalar or address register is reserved, and no unit is busy.
- R2: Issuing an instruction with `iss_vdst_en` set makes register `iss_vdst` read reserved (1) from the next clock.
- R3: A source vector register that is reserved blocks issue. The exception is the clock in which its producer gives its first element. In that clock the instruction issues, `fwd_en` bit i is set for source i, `fwd_unit`i names the producing unit, and the register reads chained (2) from the next clock.
- R4: A chained source register blocks issue, including the clock of its producer's last-element strobe. It reads idle from the next clock, and a reader then issues with no forwarding. If the first and last strobes coincide, the register goes straight to idle.
- R5: For a vector load (`iss_mem_load`), the pseudo unit number is 6 (one past the last compute unit). Its first element, and so its chain slot, falls in the seventh clock after the issue clock.
- R6: Only one vector memory operation (load or store) may be outstanding. A second one waits until the clock after `mem_last`.
- R7: A vector store (`iss_mem_store`) never chains. If its source is reserved or chained it stays blocked, even in the chain slot, until that register is idle. `fwd_en` stays 0 for it.
- R8: A vector operation cannot issue to a compute unit (0 to 5, given on `iss_unit`) that is busy with an earlier vector operation. The unit becomes free in the clock after its `fu_last` strobe.
- R9: A scalar or address register named as destination reserves that register. Any later instruction that reads it (`iss_s_use`/`iss_a_use` bit mask) or writes it is blocked up to and including the clock of its write strobe. Such registers are never forwarded.
- R10: An instruction whose vector destination is not idle is blocked.
- R11: An instruction that uses no memory and no reserved register issues while a vector load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iss_valid | input | 1 | Waiting instruction present |
| iss_ready | output | 1 | Issue grant (combinational) |
| iss_vsrc_en | input | 2 | Vector source i used |
| iss_vsrc0 | input | 3 | Vector source 0 designator |
| iss_vsrc1 | input | 3 | Vector source 1 designator |
| iss_vdst_en | input | 1 | Writes a vector register |
| iss_vdst | input | 3 | Vector destination designator |
| iss_unit | input | 3 | Target compute unit 0..5 |
| iss_mem_load | input | 1 | Vector load |
| iss_mem_store | input | 1 | Vector store (data is source 0) |
| iss_s_use | input | 8 | Scalar registers read, one bit each |
| iss_a_use | input | 8 | Address registers read, one bit each |
| iss_sdst_en | input | 1 | Writes a scalar register |
| iss_sdst | input | 3 | Scalar destination |
| iss_adst_en | input | 1 | Writes an address register |
| iss_adst | input | 3 | Address destination |
| s_wr_en | input | 1 | Scalar result written this clock |
| s_wr_idx | input | 3 | Scalar register written |
| a_wr_en | input | 1 | Address result written this clock |
| a_wr_idx | input | 3 | Address register written |
| fu_first | input | 6 | First element out of unit u |
| fu_last | input | 6 | Last element out of unit u |
| mem_last | input | 1 | Last element of the memory operation |
| fwd_en | output | 2 | Source i forwarded this clock |
| fwd_unit0 | output | 3 | Unit forwarding to source 0 |
| fwd_unit1 | output | 3 | Unit forwarding to source 1 |
| vreg_state | output | 16 | Per-register status, 2 bits each |

## Verification
`iss_ready`, `fwd_en` and the `fwd_unit` fields are combinational. They are due in the same clock as the instruction fields and strobes, so the bench settles the inputs shortly after the falling edge and samples them before the next rising edge. `vreg_state` and all reservations change at the rising edge, so their effect appears in the next sampled clock. The memory chain slot is counted by explicit clock calls, and the bench expects it in the seventh call after the load issues. A behavioural model advances on the same edges and is compared every clock. Hand-computed checks are added at the cycles each requirement names.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_RSV  = 2'd1,
    VS_CHN  = 2'd2
  } vstate_e;
endpackage

// File: rtl/vchain_vreg_track.sv
// Per vector register: status and producing unit.
module vchain_vreg_track
  import vchain_pkg::*;
#(
  parameter int NV = 8,
  parameter int UW = 3,
  localparam int VW = $clog2(NV),
  localparam int NSLOT = 1 << UW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              vdst_en,
  input  logic [VW-1:0]     vdst,
  input  logic [UW-1:0]     unit,
  input  logic [NSLOT-1:0]  first_now,
  input  logic [NSLOT-1:0]  last_now,
  output logic [2*NV-1:0]   state_flat,
  output logic [UW*NV-1:0]  prod_flat,
  output logic [NV-1:0]     slot
);
  for (genvar g = 0; g < NV; g++) begin : g_reg
    vstate_e        st;
    logic [UW-1:0]  pd;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= VS_IDLE;
        pd <= '0;
      end else if (issue && vdst_en && (vdst == VW'(g))) begin
        st <= VS_RSV;
        pd <= unit;
      end else begin
        case (st)
          VS_RSV:  if (first_now[pd]) st <= last_now[pd] ? VS_IDLE : VS_CHN;
          VS_CHN:  if (last_now[pd])  st <= VS_IDLE;
          default: st <= st;
        endcase
      end
    end

    assign slot[g]                 = (st == VS_RSV) && first_now[pd];
    assign state_flat[2*g +: 2]    = st;
    assign prod_flat[UW*g +: UW]   = pd;
  end
endmodule

// File: rtl/vchain_unit_track.sv
// Busy flags for compute units and the memory pseudo unit (slot NU).
module vchain_unit_track #(
  parameter int NU = 6,
  parameter int UW = 3,
  parameter int MEM_LAT = 7,
  localparam int NSLOT = 1 << UW,
  localparam int CW = $clog2(MEM_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              occupy,
  input  logic              load_go,
  input  logic [UW-1:0]     unit,
  input  logic [NU-1:0]     fu_first,
  input  logic [NU-1:0]     fu_last,
  input  logic              mem_last,
  output logic [NSLOT-1:0]  busy,
  output logic [NSLOT-1:0]  first_now,
  output logic [NSLOT-1:0]  last_now
);
  logic [CW-1:0] lat_cnt;

  always_comb begin
    first_now = '0;
    last_now  = '0;
    first_now[NU-1:0] = fu_first;
    last_now[NU-1:0]  = fu_last;
    first_now[NU]     = (lat_cnt == CW'(1));
    last_now[NU]      = mem_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_cnt <= '0;
    else if (load_go)        lat_cnt <= CW'(MEM_LAT);
    else if (lat_cnt != '0)  lat_cnt <= lat_cnt - CW'(1);
  end

  for (genvar u = 0; u < NSLOT; u++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          busy[u] <= 1'b0;
      else if (occupy && unit == UW'(u))   busy[u] <= 1'b1;
      else if (last_now[u])                busy[u] <= 1'b0;
    end
  end
endmodule

// File: rtl/vchain_sreg_track.sv
// Single-result reservation bits for a scalar or address register file.
module vchain_sreg_track #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  output logic [N-1:0]  rsv
);
  for (genvar r = 0; r < N; r++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rsv[r] <= 1'b0;
      else if (set_en && set_idx == IW'(r))    rsv[r] <= 1'b1;
      else if (wr_en && wr_idx == IW'(r))      rsv[r] <= 1'b0;
    end
  end
endmodule

// File: rtl/vchain_issue_ctl.sv
module vchain_issue_ctl
  import vchain_pkg::*;
#(
  parameter int NV = 8,
  parameter int NS = 8,
  parameter int NA = 8,
  parameter int NU = 6,
  parameter int MEM_LAT = 7,
  localparam int VW = $clog2(NV),
  localparam int SW = $clog2(NS),
  localparam int AW = $clog2(NA),
  localparam int UW = $clog2(NU + 1),
  localparam int NSLOT = 1 << UW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic [1:0]      iss_vsrc_en,
  input  logic [VW-1:0]   iss_vsrc0,
  input  logic [VW-1:0]   iss_vsrc1,
  input  logic            iss_vdst_en,
  input  logic [VW-1:0]   iss_vdst,
  input  logic [UW-1:0]   iss_unit,
  input  logic            iss_mem_load,
  input  logic            iss_mem_store,
  input  logic [NS-1:0]   iss_s_use,
  input  logic [NA-1:0]   iss_a_use,
  input  logic            iss_sdst_en,
  input  logic [SW-1:0]   iss_sdst,
  input  logic            iss_adst_en,
  input  logic [AW-1:0]   iss_adst,
  input  logic            s_wr_en,
  input  logic [SW-1:0]   s_wr_idx,
  input  logic            a_wr_en,
  input  logic [AW-1:0]   a_wr_idx,
  input  logic [NU-1:0]   fu_first,
  input  logic [NU-1:0]   fu_last,
  input  logic            mem_last,
  output logic [1:0]      fwd_en,
  output logic [UW-1:0]   fwd_unit0,
  output logic [UW-1:0]   fwd_unit1,
  output logic [2*NV-1:0] vreg_state
);
  logic             issue, mem_op, vec_op;
  logic [UW-1:0]    unit_eff;
  logic [NSLOT-1:0] busy, first_now, last_now;
  logic [UW*NV-1:0] prod_flat;
  logic [NV-1:0]    slot;
  logic [NS-1:0]    s_rsv;
  logic [NA-1:0]    a_rsv;
  logic [VW-1:0]    src_idx [2];
  logic [UW-1:0]    src_unit [2];
  logic [1:0]       src_ok, can_fwd;
  logic             dst_ok, unit_ok, scal_ok;

  assign mem_op   = iss_mem_load | iss_mem_store;
  assign vec_op   = iss_vdst_en | (|iss_vsrc_en) | mem_op;
  assign unit_eff = mem_op ? UW'(NU) : iss_unit;
  assign src_idx[0] = iss_vsrc0;
  assign src_idx[1] = iss_vsrc1;

  for (genvar i = 0; i < 2; i++) begin : g_src
    vstate_e st;
    assign st          = vstate_e'(vreg_state[2*int'(src_idx[i]) +: 2]);
    assign src_unit[i] = prod_flat[UW*int'(src_idx[i]) +: UW];
    assign can_fwd[i]  = iss_vsrc_en[i] && (st == VS_RSV) && slot[src_idx[i]] && !iss_mem_store;
    assign src_ok[i]   = !iss_vsrc_en[i] || (st == VS_IDLE) || can_fwd[i];
  end

  assign dst_ok  = !iss_vdst_en ||
                   (vstate_e'(vreg_state[2*int'(iss_vdst) +: 2]) == VS_IDLE);
  assign unit_ok = !vec_op || !busy[unit_eff];
  assign scal_ok = ((iss_s_use & s_rsv) == '0) && ((iss_a_use & a_rsv) == '0) &&
                   !(iss_sdst_en && s_rsv[iss_sdst]) && !(iss_adst_en && a_rsv[iss_adst]);

  assign iss_ready = (&src_ok) && dst_ok && unit_ok && scal_ok;
  assign issue     = iss_valid && iss_ready;
  assign fwd_en    = issue ? can_fwd : 2'b00;
  assign fwd_unit0 = src_unit[0];
  assign fwd_unit1 = src_unit[1];

  vchain_unit_track #(.NU(NU), .UW(UW), .MEM_LAT(MEM_LAT)) u_units (
    .clk(clk), .rst_n(rst_n),
    .occupy(issue && vec_op), .load_go(issue && iss_mem_load), .unit(unit_eff),
    .fu_first(fu_first), .fu_last(fu_last), .mem_last(mem_last),
    .busy(busy), .first_now(first_now), .last_now(last_now)
  );

  vchain_vreg_track #(.NV(NV), .UW(UW)) u_vregs (
    .clk(clk), .rst_n(rst_n),
    .issue(issue), .vdst_en(iss_vdst_en), .vdst(iss_vdst), .unit(unit_eff),
    .first_now(first_now), .last_now(last_now),
    .state_flat(vreg_state), .prod_flat(prod_flat), .slot(slot)
  );

  vchain_sreg_track #(.N(NS)) u_sregs (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue && iss_sdst_en), .set_idx(iss_sdst),
    .wr_en(s_wr_en), .wr_idx(s_wr_idx), .rsv(s_rsv)
  );

  vchain_sreg_track #(.N(NA)) u_aregs (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue && iss_adst_en), .set_idx(iss_adst),
    .wr_en(a_wr_en), .wr_idx(a_wr_idx), .rsv(a_rsv)
  );
endmodule

// File: rtl/vchain_issue_chk.sv
module vchain_issue_chk #(
  parameter int NV = 8,
  parameter int NS = 8,
  parameter int NA = 8,
  parameter int NU = 6,
  localparam int VW = $clog2(NV),
  localparam int SW = $clog2(NS),
  localparam int AW = $clog2(NA),
  localparam int UW = $clog2(NU + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [1:0]      iss_vsrc_en,
  input logic [VW-1:0]   iss_vsrc0,
  input logic [VW-1:0]   iss_vsrc1,
  input logic            iss_vdst_en,
  input logic [VW-1:0]   iss_vdst,
  input logic [UW-1:0]   iss_unit,
  input logic            iss_mem_load,
  input logic            iss_mem_store,
  input logic [NS-1:0]   iss_s_use,
  input logic [NA-1:0]   iss_a_use,
  input logic            iss_sdst_en,
  input logic [SW-1:0]   iss_sdst,
  input logic            iss_adst_en,
  input logic [AW-1:0]   iss_adst,
  input logic            s_wr_en,
  input logic [SW-1:0]   s_wr_idx,
  input logic            a_wr_en,
  input logic [AW-1:0]   a_wr_idx,
  input logic [NU-1:0]   fu_first,
  input logic [NU-1:0]   fu_last,
  input logic            mem_last,
  input logic [1:0]      fwd_en,
  input logic [UW-1:0]   fwd_unit0,
  input logic [UW-1:0]   fwd_unit1,
  input logic [2*NV-1:0] vreg_state
);
  logic go, bad_code;
  assign go = iss_valid && iss_ready;

  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < NV; i++) bad_code |= (vreg_state[2*i +: 2] == 2'd3);
  end

  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n) !bad_code);

  // R2
  vdst_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && iss_vdst_en) |=> (vreg_state[2*int'($past(iss_vdst)) +: 2] == 2'd1));

  // R3
  fwd_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en != 2'b00) |-> go);

  // R7
  store_no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_mem_store |-> (fwd_en == 2'b00));

  // R6
  mem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (iss_mem_load || iss_mem_store)) |=> !(go && (iss_mem_load || iss_mem_store)));

  // R9
  sreg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && iss_sdst_en) |=> !(go && iss_s_use[$past(iss_sdst)]));
endmodule

bind vchain_issue_ctl vchain_issue_chk #(.NV(NV), .NS(NS), .NA(NA), .NU(NU)) chk_i (.*);

// File: tb/vchain_issue_ctl_tb_top.sv
`timescale 1ns/1ps
module vchain_issue_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid, iss_ready;
  logic [1:0] iss_vsrc_en;
  logic [2:0] iss_vsrc0, iss_vsrc1, iss_vdst, iss_unit, iss_sdst, iss_adst, s_wr_idx, a_wr_idx;
  logic iss_vdst_en, iss_mem_load, iss_mem_store, iss_sdst_en, iss_adst_en, s_wr_en, a_wr_en;
  logic [7:0] iss_s_use, iss_a_use;
  logic [5:0] fu_first, fu_last;
  logic mem_last;
  logic [1:0] fwd_en;
  logic [2:0] fwd_unit0, fwd_unit1;
  logic [15:0] vreg_state;

  int checks = 0, errors = 0;
  bit done = 0;
  int mst[8], mprod[8], mbusy[8], mcnt;
  bit ms[8], ma[8];

  always #10 clk = ~clk;

  vchain_issue_ctl dut_i (.*);

  function automatic bit first_of(int u);
    if (u < 6) return fu_first[u];
    if (u == 6) return mcnt == 1;
    return 0;
  endfunction
  function automatic bit last_of(int u);
    if (u < 6) return fu_last[u];
    if (u == 6) return mem_last;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    iss_valid = 0; iss_vsrc_en = 0; iss_vsrc0 = 0; iss_vsrc1 = 0; iss_vdst_en = 0;
    iss_vdst = 0; iss_unit = 0; iss_mem_load = 0; iss_mem_store = 0;
    iss_s_use = 0; iss_a_use = 0; iss_sdst_en = 0; iss_sdst = 0; iss_adst_en = 0;
    iss_adst = 0; s_wr_en = 0; s_wr_idx = 0; a_wr_en = 0; a_wr_idx = 0;
    fu_first = 0; fu_last = 0; mem_last = 0;
  endtask

  task automatic vop(bit [1:0] sen, int s0, int s1, bit den, int d, int u, bit ld, bit st);
    iss_valid = 1; iss_vsrc_en = sen; iss_vsrc0 = 3'(s0); iss_vsrc1 = 3'(s1);
    iss_vdst_en = den; iss_vdst = 3'(d); iss_unit = 3'(u);
    iss_mem_load = ld; iss_mem_store = st;
  endtask

  // One clock: compare against the model, then advance the model at the edge.
  task automatic cyc(string tag);
    bit er, memop, vec, go;
    bit [1:0] ef;
    int eu[2], ue, src[2];
    bit [15:0] es;
    #1;
    memop = iss_mem_load | iss_mem_store;
    ue = memop ? 6 : int'(iss_unit);
    vec = iss_vdst_en | (iss_vsrc_en != 0) | memop;
    src[0] = iss_vsrc0; src[1] = iss_vsrc1;
    er = 1; ef = 0;
    for (int i = 0; i < 2; i++) begin
      eu[i] = mprod[src[i]];
      if (iss_vsrc_en[i]) begin
        if (mst[src[i]] == 1 && first_of(mprod[src[i]]) && !iss_mem_store) ef[i] = 1;
        else if (mst[src[i]] != 0) er = 0;
      end
    end
    if (iss_vdst_en && mst[iss_vdst] != 0) er = 0;
    if (vec && mbusy[ue] != 0) er = 0;
    for (int r = 0; r < 8; r++) begin
      if (ms[r] && iss_s_use[r]) er = 0;
      if (ma[r] && iss_a_use[r]) er = 0;
    end
    if (iss_sdst_en && ms[iss_sdst]) er = 0;
    if (iss_adst_en && ma[iss_adst]) er = 0;
    go = iss_valid && er;
    if (!go) ef = 0;
    for (int v = 0; v < 8; v++) es[2*v +: 2] = 2'(mst[v]);
    checks++;
    if (iss_ready !== er || fwd_en !== ef || vreg_state !== es ||
        (ef[0] && fwd_unit0 !== 3'(eu[0])) || (ef[1] && fwd_unit1 !== 3'(eu[1]))) begin
      errors++;
      $display("FAIL %s model: ready=%0d/%0d fwd=%0d/%0d u0=%0d/%0d u1=%0d/%0d state=%h/%h",
               tag, iss_ready, er, fwd_en, ef, fwd_unit0, eu[0], fwd_unit1, eu[1], vreg_state, es);
    end
    @(posedge clk);
    for (int v = 0; v < 8; v++) begin
      if (go && iss_vdst_en && iss_vdst == 3'(v)) begin mst[v] = 1; mprod[v] = ue; end
      else if (mst[v] == 1 && first_of(mprod[v])) mst[v] = last_of(mprod[v]) ? 0 : 2;
      else if (mst[v] == 2 && last_of(mprod[v])) mst[v] = 0;
    end
    for (int u = 0; u < 8; u++) begin
      if (go && vec && ue == u) mbusy[u] = 1;
      else if (last_of(u)) mbusy[u] = 0;
    end
    if (go && iss_mem_load) mcnt = 7; else if (mcnt > 0) mcnt--;
    for (int r = 0; r < 8; r++) begin
      if (go && iss_sdst_en && iss_sdst == 3'(r)) ms[r] = 1; else if (s_wr_en && s_wr_idx == 3'(r)) ms[r] = 0;
      if (go && iss_adst_en && iss_adst == 3'(r)) ma[r] = 1; else if (a_wr_en && a_wr_idx == 3'(r)) ma[r] = 0;
    end
    @(negedge clk);
  endtask

  function automatic int vst(int v);
    return int'(vreg_state[2*v +: 2]);
  endfunction

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mprod[i] = 0; mbusy[i] = 0; ms[i] = 0; ma[i] = 0; end
    mcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    vop(2'b11, 0, 1, 0, 0, 0, 0, 0); #1;
    chk(vreg_state == 0, "R1 state", vreg_state, 0);
    chk(iss_ready == 1, "R1 ready", iss_ready, 1);
    idle_in(); cyc("R1");

    // R2 reserve V2 on unit 0
    vop(2'b11, 0, 1, 1, 2, 0, 0, 0); cyc("R2");
    idle_in(); #1; chk(vst(2) == 1, "R2 V2 reserved", vst(2), 1);

    // R10 write to reserved V2 blocked
    vop(2'b00, 0, 0, 1, 2, 4, 0, 0); #1; chk(iss_ready == 0, "R10", iss_ready, 0); cyc("R10");

    // R3 reader of V2 on unit 1
    vop(2'b01, 2, 0, 1, 3, 1, 0, 0); #1; chk(iss_ready == 0, "R3 wait", iss_ready, 0); cyc("R3");
    fu_first[0] = 1; #1;
    chk(iss_ready == 1, "R3 slot ready", iss_ready, 1);
    chk(fwd_en == 2'b01, "R3 fwd_en", fwd_en, 1);
    chk(fwd_unit0 == 0, "R3 fwd_unit0", fwd_unit0, 0);
    cyc("R3");
    idle_in(); #1;
    chk(vst(2) == 2, "R3 V2 chained", vst(2), 2);
    chk(vst(3) == 1, "R3 V3 reserved", vst(3), 1);

    // R4 reader of chained V2 waits through last strobe
    vop(2'b10, 0, 2, 1, 4, 2, 0, 0); cyc("R4");
    fu_last[0] = 1; #1; chk(iss_ready == 0, "R4 at last", iss_ready, 0); cyc("R4");
    fu_last[0] = 0; #1;
    chk(iss_ready == 1, "R4 after last", iss_ready, 1);
    chk(fwd_en == 0, "R4 no fwd", fwd_en, 0);
    chk(vst(2) == 0, "R4 V2 idle", vst(2), 0);
    cyc("R4");
    idle_in(); fu_first = 6'b000110; fu_last = 6'b000110; cyc("R4");
    idle_in(); #1; chk(vst(4) == 0 && vst(3) == 0, "R4 first=last idle", vreg_state, 0);

    // R8 unit busy
    vop(2'b00, 0, 0, 1, 5, 0, 0, 0); cyc("R8");
    vop(2'b00, 0, 0, 1, 6, 0, 0, 0); #1; chk(iss_ready == 0, "R8 busy", iss_ready, 0); cyc("R8");
    fu_first[0] = 1; fu_last[0] = 1; #1; chk(iss_ready == 0, "R8 at last", iss_ready, 0); cyc("R8");
    fu_first = 0; fu_last = 0; #1; chk(iss_ready == 1, "R8 freed", iss_ready, 1); cyc("R8");
    idle_in(); fu_first[0] = 1; fu_last[0] = 1; cyc("R8");

    // R5, R6, R11 memory load into V1
    idle_in(); vop(2'b00, 0, 0, 1, 1, 0, 1, 0); cyc("R5");
    vop(2'b01, 0, 0, 1, 0, 4, 0, 0); #1; chk(iss_ready == 1, "R11 indep", iss_ready, 1); cyc("R11");
    vop(2'b00, 0, 0, 1, 6, 0, 1, 0); #1; chk(iss_ready == 0, "R6 second load", iss_ready, 0); cyc("R6");
    for (int k = 3; k <= 6; k++) begin
      vop(2'b01, 1, 0, 1, 7, 3, 0, 0);
      if (k == 3) begin fu_first[4] = 1; fu_last[4] = 1; end else begin fu_first = 0; fu_last = 0; end
      #1; chk(iss_ready == 0, "R5 before slot", iss_ready, 0); cyc("R5");
    end
    fu_first = 0; fu_last = 0; #1;
    chk(iss_ready == 1, "R5 slot", iss_ready, 1);
    chk(fwd_unit0 == 6 && fwd_en == 2'b01, "R5 mem fwd", fwd_unit0, 6);
    cyc("R5");
    idle_in(); cyc("R5");
    vop(2'b00, 0, 0, 1, 6, 0, 1, 0); mem_last = 1; #1; chk(iss_ready == 0, "R6 at last", iss_ready, 0); cyc("R6");
    mem_last = 0; #1; chk(iss_ready == 1, "R6 after last", iss_ready, 1); cyc("R6");
    idle_in(); fu_first[3] = 1; fu_last[3] = 1; cyc("R6");
    idle_in(); repeat (7) cyc("R6");
    mem_last = 1; cyc("R6");
    idle_in(); #1; chk(vreg_state == 0, "R6 drained", vreg_state, 0);

    // R7 store of V2 cannot chain
    vop(2'b00, 0, 0, 1, 2, 0, 0, 0); cyc("R7");
    vop(2'b01, 2, 0, 0, 0, 0, 0, 1); #1; chk(iss_ready == 0, "R7 reserved", iss_ready, 0); cyc("R7");
    fu_first[0] = 1; #1;
    chk(iss_ready == 0, "R7 in slot", iss_ready, 0);
    chk(fwd_en == 0, "R7 no fwd", fwd_en, 0);
    cyc("R7");
    fu_first = 0; fu_last[0] = 1; cyc("R7");
    fu_last = 0; #1; chk(iss_ready == 1, "R7 idle source", iss_ready, 1); cyc("R7");
    idle_in(); mem_last = 1; cyc("R7");

    // R9 scalar and address reservations
    idle_in(); iss_valid = 1; iss_unit = 5; iss_sdst_en = 1; iss_sdst = 3; iss_adst_en = 1; iss_adst = 1; cyc("R9");
    idle_in(); iss_valid = 1; iss_s_use = 8'h08; #1; chk(iss_ready == 0, "R9 S read", iss_ready, 0); cyc("R9");
    s_wr_en = 1; s_wr_idx = 3; #1; chk(iss_ready == 0, "R9 at write", iss_ready, 0); cyc("R9");
    s_wr_en = 0; #1; chk(iss_ready == 1 && fwd_en == 0, "R9 S free", iss_ready, 1); cyc("R9");
    idle_in(); iss_valid = 1; iss_adst_en = 1; iss_adst = 1; #1; chk(iss_ready == 0, "R9 A dest", iss_ready, 0); cyc("R9");
    a_wr_en = 1; a_wr_idx = 1; cyc("R9");
    a_wr_en = 0; #1; chk(iss_ready == 1, "R9 A free", iss_ready, 1); cyc("R9");

    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      idle_in();
      op = int'($urandom_range(0, 9));
      iss_valid = ($urandom_range(0, 3) != 0);
      iss_vsrc_en = 2'($urandom); iss_vsrc0 = 3'($urandom); iss_vsrc1 = 3'($urandom);
      iss_vdst_en = ($urandom_range(0, 1) != 0); iss_vdst = 3'($urandom);
      iss_unit = 3'($urandom_range(0, 5));
      if (op == 0) begin iss_mem_load = 1; iss_vdst_en = 1; end
      if (op == 1) begin iss_mem_store = 1; iss_vdst_en = 0; iss_vsrc_en = 2'b01; end
      iss_s_use = 8'($urandom) & 8'($urandom) & 8'($urandom);
      iss_a_use = 8'($urandom) & 8'($urandom) & 8'($urandom);
      iss_sdst_en = ($urandom_range(0, 3) == 0); iss_sdst = 3'($urandom);
      iss_adst_en = ($urandom_range(0, 3) == 0); iss_adst = 3'($urandom);
      s_wr_en = ($urandom_range(0, 2) == 0); s_wr_idx = 3'($urandom);
      a_wr_en = ($urandom_range(0, 2) == 0); a_wr_idx = 3'($urandom);
      fu_first = 6'($urandom) & 6'($urandom);
      fu_last = 6'($urandom) & 6'($urandom) & 6'($urandom);
      mem_last = ($urandom_range(0, 7) == 0);
      cyc("R3 R4 mixed");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule